// File: doc/BRIEF.md
# Package Sleep-State Sequencer

This block decides how deep a two-core processor package may sleep and tracks the package through its low-power states. Each core reports the C-state it has requested. The block combines the two requests into a target package state. The shallower core sets the limit, so the package never sleeps deeper than the more awake core permits.

A state machine then follows the system's active-low sideband controls. These are stop-clock, sleep, deep-sleep and deeper-stop, along with snoop-arrival and snoop-done strobes. The machine moves one level at a time through the chain Normal, Stop-Grant, Sleep, Deep Sleep and Deeper Sleep. A snoop side-state can be reached only from Stop-Grant. A moves deeper happens only when the target allows that depth. A move back toward Normal always happens.

A one-cycle error flag reports any sideband edge that arrives in a state where that signal has no meaning. The block does not regulate voltage and does not gate any clock.

Top module: `pkg_sleep_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pkg_state` to Normal (0) and clears `seq_err`.
- R2: `target_state` is combinational from the core requests, coded C0=0 through C4=4. Take m as the lower of the two requests. If m is 0 or 1, the target is Normal (0). If m is 2, the target is Stop-Grant (1). If m is 3, the target is Deep Sleep (4). If m is 4, the target is Deeper Sleep (5).
- R3: `pkg_state` is coded as follows: Normal=0, Stop-Grant=1, Snoop=2, Sleep=3, Deep=4, Deeper=5. In Normal, a low `stpclk_n` moves the package to Stop-Grant at the next edge. In Stop-Grant, a high `stpclk_n` moves it back to Normal.
- R4: In Stop-Grant, a high `snoop_hit` moves the package to Snoop. In Snoop, a high `snoop_done` moves it back to Stop-Grant.
- R5: In Stop-Grant, a low `slp_n` moves the package to Sleep. In Sleep, a high `slp_n` moves it back to Stop-Grant.
- R6: In Sleep, a low `dpslp_n` moves the package to Deep. In Deep, a high `dpslp_n` moves it back to Sleep.
- R7: In Deep, a low `dprstp_n` moves the package to Deeper. In Deeper, a high `dprstp_n` moves it back to Deep.
- R8: The package moves at most one level per clock. A control that belongs to a deeper level has no effect until the package reaches the state just above that level.
- R9: Each deeper move needs the target's permission. Stop-Grant needs a target other than Normal. Sleep and Deep need a target of Deep or Deeper. Deeper needs a target of Deeper. Moves toward Normal happen whatever the target is.
- R10: Some sideband edges have no defined effect in the current state. Stop-clock is defined only in Normal and Stop-Grant. Sleep is defined in Stop-Grant and Sleep. Deep-sleep is defined in Sleep and Deep. Deeper-stop is defined in Deep and Deeper. An edge outside these states raises `seq_err` for exactly one cycle after the edge where it is seen.
- R11: In Stop-Grant, leaving for Normal takes priority over entering Snoop, and entering Snoop takes priority over entering Sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core0_cs | input | 3 | C-state requested by core 0 (0..4) |
| core1_cs | input | 3 | C-state requested by core 1 (0..4) |
| stpclk_n | input | 1 | Stop-clock request, active low |
| slp_n | input | 1 | Sleep request, active low |
| dpslp_n | input | 1 | Deep-sleep request, active low |
| dprstp_n | input | 1 | Deeper-stop request, active low |
| snoop_hit | input | 1 | A snoop has arrived |
| snoop_done | input | 1 | The snoop has been serviced |
| pkg_state | output | 3 | Current package state |
| target_state | output | 3 | Deepest package state the cores permit |
| seq_err | output | 1 | One-cycle flag for an undefined sideband edge |

## Verification
`target_state` has no register in its path. The bench reads it 1 ns after changing the core requests, with no clock edge in between. `pkg_state` and `seq_err` each pass through one register, so both are due in the cycle right after the edge that sees the stimulus. The bench drives inputs 2 ns after a rising edge and reads results 2 ns after the next rising edge, so every check falls one edge after its cause. The bench also reads `seq_err` one edge later again to confirm the flag lasts only one cycle. Level-held controls that skip levels are checked edge by edge, so the bench can confirm that each edge moves the package by one step only.

// File: rtl/pkg_sleep_seq.sv
module pkg_sleep_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] core0_cs,
  input  logic [2:0] core1_cs,
  input  logic       stpclk_n,
  input  logic       slp_n,
  input  logic       dpslp_n,
  input  logic       dprstp_n,
  input  logic       snoop_hit,
  input  logic       snoop_done,
  output logic [2:0] pkg_state,
  output logic [2:0] target_state,
  output logic       seq_err
);

  typedef enum logic [2:0] {
    ST_NORM = 3'd0, ST_SG = 3'd1, ST_SNP = 3'd2,
    ST_SLP = 3'd3, ST_DEEP = 3'd4, ST_DPR = 3'd5
  } pst_t;

  pst_t state, nxt;
  logic [2:0] lo_cs;
  logic [3:0] sb_now, sb_prev, sb_def;
  logic       ok_sg, ok_slp, ok_dpr;

  assign lo_cs = (core0_cs < core1_cs) ? core0_cs : core1_cs;
  assign target_state = (lo_cs <= 3'd1) ? ST_NORM :
                        (lo_cs == 3'd2) ? ST_SG   :
                        (lo_cs == 3'd3) ? ST_DEEP : ST_DPR;

  assign ok_sg  = target_state != ST_NORM;
  assign ok_slp = target_state == ST_DEEP || target_state == ST_DPR;
  assign ok_dpr = target_state == ST_DPR;

  always_comb begin
    nxt = state;
    case (state)
      ST_NORM: if (!stpclk_n && ok_sg) nxt = ST_SG;
      ST_SG: begin
        if (stpclk_n)                nxt = ST_NORM;
        else if (snoop_hit)          nxt = ST_SNP;
        else if (!slp_n && ok_slp)   nxt = ST_SLP;
      end
      ST_SNP:  if (snoop_done) nxt = ST_SG;
      ST_SLP: begin
        if (slp_n)                   nxt = ST_SG;
        else if (!dpslp_n && ok_slp) nxt = ST_DEEP;
      end
      ST_DEEP: begin
        if (dpslp_n)                 nxt = ST_SLP;
        else if (!dprstp_n && ok_dpr) nxt = ST_DPR;
      end
      ST_DPR:  if (dprstp_n) nxt = ST_DEEP;
      default: nxt = ST_NORM;
    endcase
  end

  assign sb_now = {dprstp_n, dpslp_n, slp_n, stpclk_n};
  assign sb_def = {state == ST_DEEP || state == ST_DPR,
                   state == ST_SLP  || state == ST_DEEP,
                   state == ST_SG   || state == ST_SLP,
                   state == ST_NORM || state == ST_SG};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_NORM;
      sb_prev <= 4'hF;
      seq_err <= 1'b0;
    end else begin
      state   <= nxt;
      sb_prev <= sb_now;
      seq_err <= |((sb_now ^ sb_prev) & ~sb_def);
    end
  end

  assign pkg_state = state;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pkg_state == 3'd0 && !seq_err));

  // R2
  shallow_core_chk: assert property (@(posedge clk) disable iff (rst)
    (core0_cs < 3'd2 || core1_cs < 3'd2) |-> target_state == 3'd0);

  // R3
  normal_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == 3'd1 && stpclk_n) |=> pkg_state == 3'd0);

  // R8
  normal_step_chk: assert property (@(posedge clk) disable iff (rst)
    pkg_state == 3'd0 |=> (pkg_state == 3'd0 || pkg_state == 3'd1));

  // R8
  sg_step_chk: assert property (@(posedge clk) disable iff (rst)
    pkg_state == 3'd1 |=> pkg_state <= 3'd3);

  // R9
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == 3'd1 && target_state <= 3'd1) |=> pkg_state != 3'd3);

  // R9
  deeper_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == 3'd4 && target_state != 3'd5) |=> pkg_state != 3'd5);

  // R4
  snoop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pkg_state == 3'd2 && !snoop_done) |=> pkg_state == 3'd2);

  // R10
  no_edge_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(stpclk_n) && $stable(slp_n) && $stable(dpslp_n) && $stable(dprstp_n))
      |=> !seq_err);

endmodule

// File: tb/sim_pkg_sleep_seq.sv
`timescale 1ns/1ps
module sim_pkg_sleep_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] core0_cs = 3'd0, core1_cs = 3'd0;
  logic stpclk_n = 1'b1, slp_n = 1'b1, dpslp_n = 1'b1, dprstp_n = 1'b1;
  logic snoop_hit = 1'b0, snoop_done = 1'b0;
  logic [2:0] pkg_state, target_state;
  logic seq_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pkg_sleep_seq u0 (.*);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic cores(int a, int b);
    core0_cs = 3'(a); core1_cs = 3'(b);
  endtask

  task automatic t_reset();
    rst = 1'b1; tick(); tick();
    chk("R1 state", pkg_state, 0);
    chk("R1 err", seq_err, 0);
    rst = 1'b0;
  endtask

  task automatic t_target();
    int a[8] = '{0, 1, 2, 4, 3, 4, 3, 2};
    int b[8] = '{4, 4, 4, 2, 4, 4, 3, 2};
    int e[8] = '{0, 0, 1, 1, 4, 5, 4, 1};
    for (int i = 0; i < 8; i++) begin
      cores(a[i], b[i]); #1;
      chk("R2 target", target_state, e[i]);
    end
  endtask

  task automatic t_walk();
    cores(4, 4);
    stpclk_n = 0; tick(); chk("R3 enter sg", pkg_state, 1);
    slp_n = 0;    tick(); chk("R5 enter sleep", pkg_state, 3);
    dpslp_n = 0;  tick(); chk("R6 enter deep", pkg_state, 4);
    dprstp_n = 0; tick(); chk("R7 enter deeper", pkg_state, 5);
    chk("R10 no err on legal walk", seq_err, 0);
    dprstp_n = 1; tick(); chk("R7 leave deeper", pkg_state, 4);
    dpslp_n = 1;  tick(); chk("R6 leave deep", pkg_state, 3);
    slp_n = 1;    tick(); chk("R5 leave sleep", pkg_state, 1);
    stpclk_n = 1; tick(); chk("R3 leave sg", pkg_state, 0);
    chk("R10 no err on legal exit", seq_err, 0);
  endtask

  task automatic t_snoop();
    cores(2, 2);
    stpclk_n = 0; tick(); chk("R3 sg", pkg_state, 1);
    snoop_hit = 1; tick(); chk("R4 snoop enter", pkg_state, 2);
    snoop_hit = 0; tick(); chk("R4 snoop hold", pkg_state, 2);
    snoop_done = 1; tick(); chk("R4 snoop exit", pkg_state, 1);
    snoop_done = 0;
    snoop_hit = 1; stpclk_n = 1; tick();
    chk("R11 exit beats snoop", pkg_state, 0);
    snoop_hit = 0; tick();
    cores(4, 4);
    stpclk_n = 0; tick();
    snoop_hit = 1; slp_n = 0; tick();
    chk("R11 snoop beats sleep", pkg_state, 2);
    snoop_hit = 0; snoop_done = 1; tick(); chk("R4 back to sg", pkg_state, 1);
    snoop_done = 0; slp_n = 1; tick(); chk("R5 sleep released", pkg_state, 1);
    stpclk_n = 1; tick(); chk("R3 normal", pkg_state, 0);
  endtask

  task automatic t_gate();
    cores(0, 4);
    stpclk_n = 0; tick(); chk("R9 sg blocked by C0 core", pkg_state, 0);
    cores(2, 2); tick(); chk("R9 sg allowed", pkg_state, 1);
    slp_n = 0; tick(); chk("R9 sleep blocked at C2", pkg_state, 1);
    cores(3, 3); tick(); chk("R9 sleep allowed at C3", pkg_state, 3);
    dpslp_n = 0; tick(); chk("R9 deep allowed at C3", pkg_state, 4);
    dprstp_n = 0; tick(); chk("R9 deeper blocked at C3", pkg_state, 4);
    cores(0, 0);
    dprstp_n = 1; tick(); chk("R9 exit ok, stays deep", pkg_state, 4);
    dpslp_n = 1; tick(); chk("R9 exit honoured at C0", pkg_state, 3);
    slp_n = 1; tick(); chk("R9 exit to sg", pkg_state, 1);
    stpclk_n = 1; tick(); chk("R9 exit to normal", pkg_state, 0);
    chk("R10 gated edges legal", seq_err, 0);
  endtask

  task automatic t_skip();
    cores(4, 4);
    stpclk_n = 0; slp_n = 0; dpslp_n = 0; dprstp_n = 0;
    tick(); chk("R8 one step", pkg_state, 1);
    chk("R10 err on skipped edges", seq_err, 1);
    tick(); chk("R8 second step", pkg_state, 3);
    chk("R10 err one cycle", seq_err, 0);
    tick(); chk("R8 third step", pkg_state, 4);
    tick(); chk("R8 fourth step", pkg_state, 5);
    stpclk_n = 1; slp_n = 1; dpslp_n = 1; dprstp_n = 1;
    tick(); chk("R8 one step up", pkg_state, 4);
    chk("R10 err on release", seq_err, 1);
    tick(); chk("R8 step up 2", pkg_state, 3);
    chk("R10 err cleared", seq_err, 0);
    tick(); chk("R8 step up 3", pkg_state, 1);
    tick(); chk("R8 step up 4", pkg_state, 0);
  endtask

  task automatic t_err();
    cores(4, 4);
    dpslp_n = 0; tick();
    chk("R10 deep edge in normal", seq_err, 1);
    chk("R8 ignored in normal", pkg_state, 0);
    tick(); chk("R10 pulse ends", seq_err, 0);
    dpslp_n = 1; tick(); chk("R10 release edge", seq_err, 1);
    tick(); chk("R10 quiet", seq_err, 0);
    rst = 1; tick(); rst = 0;
    chk("R1 reset again", pkg_state, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_target();
    t_walk();
    t_snoop();
    t_gate();
    t_skip();
    t_err();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule